// File: doc/BRIEF.md
# Rotation and Index Event Monitor

This block counts whole revolutions of a quadrature encoder and turns the notable moments of that count into interrupt events. An upstream position counter supplies one-cycle pulses each time it wraps forward or backward. The block folds those pulses into a 12-bit rotation counter, which wraps in both directions. Each wrap direction is reported as its own event. A further event fires when the rotation counter reaches a programmable compare value.

A synchronized index pulse from the encoder is also watched, as long as index detection is enabled. Every enabled index pulse raises an index event. The current position counter value is sampled at that pulse, and a nonzero value raises a position error event, because the index mark should coincide with position zero.

Every event sets a sticky status bit. Software clears status bits through write-one-to-clear strobes. A mask register selects which status bits may drive the single combined interrupt output.

Top module: `rot_event_monitor`

## Requirements
- R1: A reverse step while the rotation counter is 0 makes the counter 0xFFF. At the same clock edge it sets the underflow status bit, `status[0]`.
- R2: A forward step while the rotation counter is 0xFFF makes the counter 0. At the same clock edge it sets the overflow status bit, `status[1]`.
- R3: `fwdWrap` alone increments the rotation counter by one at the next edge. `revWrap` alone decrements it by one. Both pulses high together, or neither, leave it unchanged.
- R4: The compare status bit, `status[2]`, is set one edge after the rotation counter first becomes equal to `cmpValue`. This holds whether the counter moved or `cmpValue` changed. A match that persists does not set the bit again once it has been cleared.
- R5: An `indexPulse` with `indexEn` high sets the index status bit, `status[3]`, at the next edge. With `indexEn` low, the pulse has no effect.
- R6: An `indexPulse` with `indexEn` high and a nonzero `posCount` sets the position error bit, `status[4]`, at the next edge. With `posCount` equal to zero, or with `indexEn` low, `status[4]` is not set.
- R7: Status bits are sticky and are set regardless of the mask. A high `clearStatus[k]` clears `status[k]` at the next edge. If a set and a clear of the same bit arrive in the same cycle, the set wins.
- R8: The mask register `mask` resets to all zeros. It loads `maskWrData` at an edge where `maskWrEn` is high and otherwise holds its value. Bit k equal to 1 masks `status[k]`.
- R9: `irq` is high exactly when at least one status bit is set and its mask bit is 0. With all mask bits set, `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fwdWrap | input | 1 | Forward wrap pulse from the position counter |
| revWrap | input | 1 | Reverse wrap pulse from the position counter |
| indexPulse | input | 1 | Synchronized one-cycle index pulse |
| indexEn | input | 1 | Index detection enable |
| posCount | input | POS_W (16) | Current position counter value |
| cmpValue | input | ROT_W (12) | Rotation compare value |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 5 | New mask value |
| clearStatus | input | 5 | Write-one-to-clear strobes, one per status bit |
| rotCount | output | ROT_W (12) | Rotation counter |
| status | output | 5 | Sticky event status bits |
| mask | output | 5 | Mask register |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take the wrap and index inputs to be synchronous to `clk`. They also take each pulse to last one cycle per event. A held pulse would count as repeated events, which is legal but not what the properties describe. The stimulus drives every pulse for exactly one cycle on the falling edge. It sweeps the rotation counter through all 4096 values in both directions against an arithmetic model of the count. It also exercises simultaneous forward and reverse pulses, a compare value that is moved onto the current count, and index pulses with detection both on and off.

// File: rtl/rotmon_pkg.sv
package rotmon_pkg;
  localparam int EV_N    = 5;
  localparam int EV_UNF  = 0;
  localparam int EV_OVF  = 1;
  localparam int EV_CMP  = 2;
  localparam int EV_IDX  = 3;
  localparam int EV_PERR = 4;

  typedef struct packed {
    logic inc;
    logic dec;
    logic ovf;
    logic unf;
    logic idx;
    logic posErr;
  } ctrl_strobe_t;
endpackage

// File: rtl/rot_event_ctrl.sv
module rot_event_ctrl
  import rotmon_pkg::*;
#(
  parameter int ROT_W = 12,
  parameter int POS_W = 16
) (
  input  logic             fwdWrap,
  input  logic             revWrap,
  input  logic             indexPulse,
  input  logic             indexEn,
  input  logic [POS_W-1:0] posCount,
  input  logic [ROT_W-1:0] rotCount,
  output ctrl_strobe_t     strobe
);
  localparam logic [ROT_W-1:0] ROT_MAX = '1;

  always_comb begin
    strobe.inc    = fwdWrap & ~revWrap;
    strobe.dec    = revWrap & ~fwdWrap;
    strobe.ovf    = strobe.inc && (rotCount == ROT_MAX);
    strobe.unf    = strobe.dec && (rotCount == '0);
    strobe.idx    = indexPulse & indexEn;
    strobe.posErr = strobe.idx && (posCount != '0);
  end
endmodule

// File: rtl/rot_event_dp.sv
module rot_event_dp
  import rotmon_pkg::*;
#(
  parameter int ROT_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic [ROT_W-1:0] cmpValue,
  input  logic             maskWrEn,
  input  logic [EV_N-1:0]  maskWrData,
  input  logic [EV_N-1:0]  clearStatus,
  output logic [ROT_W-1:0] rotCount,
  output logic [EV_N-1:0]  status,
  output logic [EV_N-1:0]  mask,
  output logic             irq
);
  logic            eqNow;
  logic            eqPrev;
  logic [EV_N-1:0] setVec;

  // rotation counter
  always_ff @(posedge clk) begin
    if (!rstN)           rotCount <= '0;
    else if (strobe.inc) rotCount <= rotCount + 1'b1;
    else if (strobe.dec) rotCount <= rotCount - 1'b1;
  end

  // edge detect on equality so a lasting match fires once
  assign eqNow = (rotCount == cmpValue);
  always_ff @(posedge clk) begin
    if (!rstN) eqPrev <= 1'b0;
    else       eqPrev <= eqNow;
  end

  always_comb begin
    setVec          = '0;
    setVec[EV_UNF]  = strobe.unf;
    setVec[EV_OVF]  = strobe.ovf;
    setVec[EV_CMP]  = eqNow & ~eqPrev;
    setVec[EV_IDX]  = strobe.idx;
    setVec[EV_PERR] = strobe.posErr;
  end

  // sticky status, set beats clear
  for (genvar k = 0; k < EV_N; k++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN)          status[k] <= 1'b0;
      else if (setVec[k]) status[k] <= 1'b1;
      else if (clearStatus[k]) status[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         mask <= '0;
    else if (maskWrEn) mask <= maskWrData;
  end

  assign irq = |(status & ~mask);
endmodule

// File: rtl/rot_event_monitor.sv
module rot_event_monitor
  import rotmon_pkg::*;
#(
  parameter int ROT_W = 12,
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fwdWrap,
  input  logic             revWrap,
  input  logic             indexPulse,
  input  logic             indexEn,
  input  logic [POS_W-1:0] posCount,
  input  logic [ROT_W-1:0] cmpValue,
  input  logic             maskWrEn,
  input  logic [4:0]       maskWrData,
  input  logic [4:0]       clearStatus,
  output logic [ROT_W-1:0] rotCount,
  output logic [4:0]       status,
  output logic [4:0]       mask,
  output logic             irq
);
  ctrl_strobe_t strobe;

  rot_event_ctrl #(.ROT_W(ROT_W), .POS_W(POS_W)) u_ctrl (
    .fwdWrap(fwdWrap), .revWrap(revWrap), .indexPulse(indexPulse),
    .indexEn(indexEn), .posCount(posCount), .rotCount(rotCount),
    .strobe(strobe)
  );

  rot_event_dp #(.ROT_W(ROT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpValue(cmpValue),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData), .clearStatus(clearStatus),
    .rotCount(rotCount), .status(status), .mask(mask), .irq(irq)
  );
endmodule

// File: rtl/rot_event_monitor_chk.sv
module rot_event_monitor_chk #(
  parameter int ROT_W = 12,
  parameter int POS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             fwdWrap,
  input logic             revWrap,
  input logic             indexPulse,
  input logic             indexEn,
  input logic [POS_W-1:0] posCount,
  input logic [ROT_W-1:0] rotCount,
  input logic [4:0]       status,
  input logic [4:0]       mask,
  input logic             maskWrEn,
  input logic [4:0]       clearStatus,
  input logic             irq
);
  p_underflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    (revWrap && !fwdWrap && rotCount == '0) |=> (rotCount == '1 && status[0]));

  p_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fwdWrap && !revWrap && rotCount == '1) |=> (rotCount == '0 && status[1]));

  p_both_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fwdWrap == revWrap) |=> $stable(rotCount));

  p_idx_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (indexPulse && !indexEn && !status[3]) |=> !status[3]);

  p_pos_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    (indexPulse && indexEn && posCount != '0) |=> status[4]);

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !maskWrEn |=> $stable(mask));

  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mask == 5'h1F) |-> !irq);

  for (genvar k = 0; k < 5; k++) begin : g_sticky
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (status[k] && !clearStatus[k]) |=> status[k]);
  end
endmodule

bind rot_event_monitor rot_event_monitor_chk #(.ROT_W(ROT_W), .POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .fwdWrap(fwdWrap), .revWrap(revWrap),
  .indexPulse(indexPulse), .indexEn(indexEn), .posCount(posCount),
  .rotCount(rotCount), .status(status), .mask(mask), .maskWrEn(maskWrEn),
  .clearStatus(clearStatus), .irq(irq)
);

// File: tb/rot_event_monitor_tb.sv
`timescale 1ns/1ps
module rot_event_monitor_tb;
  localparam int ROT_W = 12;
  localparam int POS_W = 16;
  localparam int ROT_N = 1 << ROT_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             fwdWrap = 1'b0, revWrap = 1'b0;
  logic             indexPulse = 1'b0, indexEn = 1'b0;
  logic [POS_W-1:0] posCount = '0;
  logic [ROT_W-1:0] cmpValue = 12'h800;
  logic             maskWrEn = 1'b0;
  logic [4:0]       maskWrData = '0;
  logic [4:0]       clearStatus = '0;
  logic [ROT_W-1:0] rotCount;
  logic [4:0]       status, mask;
  logic             irq;

  int nChecks = 0;
  int nFail = 0;
  int model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rot_event_monitor #(.ROT_W(ROT_W), .POS_W(POS_W)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic f, input logic r);
    fwdWrap = f; revWrap = r;
    tick();
    fwdWrap = 1'b0; revWrap = 1'b0;
  endtask

  task automatic clearBits(input logic [4:0] bits);
    clearStatus = bits;
    tick();
    clearStatus = '0;
  endtask

  task automatic writeMask(input logic [4:0] v);
    maskWrEn = 1'b1; maskWrData = v;
    tick();
    maskWrEn = 1'b0;
  endtask

  task automatic idx(input logic en, input logic [POS_W-1:0] pos);
    indexEn = en; posCount = pos; indexPulse = 1'b1;
    tick();
    indexPulse = 1'b0;
  endtask

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    check("R3 reset count", int'(rotCount), 0);
    check("R7 reset status", int'(status), 0);
    check("R8 reset mask", int'(mask), 0);
    check("R9 reset irq", int'(irq), 0);

    // forward sweep through every value
    model = 0;
    for (int i = 0; i < ROT_N; i++) begin
      pulse(1'b1, 1'b0);
      model = (model + 1) % ROT_N;
      check("R3 fwd count", int'(rotCount), model);
      check("R2 overflow", int'(status[1]), (i == ROT_N - 1) ? 1 : 0);
      if (model == int'(cmpValue)) begin
        tick();
        check("R4 compare set", int'(status[2]), 1);
        clearBits(5'b00100);
        repeat (3) tick();
        check("R4 compare once", int'(status[2]), 0);
      end
    end
    clearBits(5'h1F);
    check("R7 clear all", int'(status), 0);

    // reverse sweep
    for (int i = 0; i < ROT_N; i++) begin
      pulse(1'b0, 1'b1);
      model = (model + ROT_N - 1) % ROT_N;
      check("R3 rev count", int'(rotCount), model);
      check("R1 underflow", int'(status[0]), 1);
      if (i == 0) check("R1 wrap value", int'(rotCount), 12'hFFF);
    end
    tick();
    clearBits(5'h1F);
    check("R1 back to zero", int'(rotCount), 0);

    // simultaneous pulses
    pulse(1'b1, 1'b1);
    check("R3 both hold", int'(rotCount), 0);
    check("R3 both no wrap", int'(status[1:0]), 0);

    // compare value moved onto current count
    cmpValue = 12'h000;
    tick();
    tick();
    check("R4 cmp move", int'(status[2]), 1);
    clearBits(5'b00100);
    repeat (4) tick();
    check("R4 persistent match", int'(status[2]), 0);
    cmpValue = 12'h800;
    tick();

    // index disabled
    idx(1'b0, 16'd5);
    tick();
    check("R5 idx disabled", int'(status[3]), 0);
    check("R6 perr disabled", int'(status[4]), 0);
    // enabled, position zero
    idx(1'b1, 16'd0);
    check("R5 idx enabled", int'(status[3]), 1);
    check("R6 no perr at zero", int'(status[4]), 0);
    // enabled, position nonzero
    idx(1'b1, 16'd7);
    check("R6 perr", int'(status[4]), 1);
    clearBits(5'h1F);

    // set beats clear
    indexEn = 1'b1; posCount = '0; indexPulse = 1'b1; clearStatus = 5'b01000;
    tick();
    indexPulse = 1'b0; clearStatus = '0;
    check("R7 set wins", int'(status[3]), 1);
    check("R9 irq unmasked", int'(irq), 1);

    writeMask(5'h1F);
    check("R8 mask load", int'(mask), 5'h1F);
    check("R9 all masked", int'(irq), 0);
    writeMask(5'b10111);
    check("R9 idx unmasked", int'(irq), 1);
    writeMask(5'b01000);
    check("R9 only idx masked", int'(irq), 0);
    tick();
    check("R8 mask hold", int'(mask), 5'b01000);
    writeMask(5'h00);
    clearBits(5'b01000);
    check("R7 clear idx", int'(status[3]), 0);
    check("R9 irq cleared", int'(irq), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule